// File: doc/BRIEF.md
# Ethernet Receive Destination-Address Filter

This block decides whether an incoming Ethernet frame is kept or thrown away, based only on its 48-bit destination address. An upstream frame parser presents the address with a one-cycle strobe. One clock later the filter returns a one-cycle decision pulse carrying an accept flag. The decision combines three sources: exact comparison against two programmable station addresses, acceptance of the all-ones broadcast address, and a 64-entry single-bit hash table for group (multicast) addresses.

Software programs the filter through a simple word-addressed write port. Each station address is split over two 32-bit words with little-endian byte packing. The 64-bit group table is split into a low and a high word. A receive control word holds the enable bits. The hash index folds all 48 address bits into 6 bits by XOR. A mode bit lets individual addresses use the hash table as well.

The decision path is a two-state machine. In `ST_IDLE` no decision is reported. The transition `GO_REPORT` is taken on any cycle in which the address strobe is high, and leads to `ST_REPORT`, where the registered decision is shown for one cycle. From `ST_REPORT`, the transition `STAY_REPORT` is taken when another strobe arrives in that cycle. Otherwise the transition `BACK_IDLE` returns the machine to `ST_IDLE`.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset every configuration register is zero, `dec_valid` is low, and any presented address is reported with `dec_accept` = 0.
- R2: `dec_valid` is high in exactly the cycle after each cycle in which `addr_valid` is high, including back-to-back strobes. It is low otherwise, and `dec_accept` is low whenever `dec_valid` is low.
- R3: With control bit 0 set, an address equal to station address 0 is accepted. Station 0 takes address bytes 0..3 from word offset 0 (byte 0 in bits 7:0) and bytes 4..5 from bits 15:0 of word offset 1. Address byte 0 is `dst_addr[7:0]`.
- R4: With control bit 1 set, an address equal to station address 1 is accepted. Station 1 uses the same packing at word offsets 2 and 3.
- R5: With control bit 3 set, the all-ones address is accepted.
- R6: The hash index is the XOR of the eight 6-bit slices of `dst_addr`. An index below 32 selects that bit of the group word at offset 4. An index of 32 or more selects bit (index − 32) of the group word at offset 5. An address with `dst_addr[0]` = 1 is accepted when the selected bit is 1.
- R7: An address with `dst_addr[0]` = 0 never hits the hash table unless control bit 2 is set. With bit 2 set, it is looked up in the table like a group address.
- R8: A station address whose enable bit is clear does not cause acceptance, even when the address equals it.
- R9: Writes to word offset 6 and to offsets 8..15 change nothing. Bits 31:16 of the words at offsets 1 and 3 are ignored. The receive control word sits at offset 7, and only its bits 3:0 are kept.
- R10: `dec_accept` is the OR of all enabled sources: a frame is accepted when any one of them hits, and dropped when none does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_ofs | input | 4 | Word offset of the write |
| cfg_data | input | 32 | Write data |
| addr_valid | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| dec_valid | output | 1 | Decision pulse, one cycle after the strobe |
| dec_accept | output | 1 | Frame accepted (qualified by `dec_valid`) |

## Verification
A wrong internal state shows up at the ports in the decision cycle, exactly one clock after the address strobe. A register that latched a bad value, such as a wrong byte lane, wrong table half or ignored bits kept, turns a programmed match into a drop or a drop into an accept. A stuck state machine shows as a missing, stretched or stray `dec_valid` pulse. The directed tests therefore program a register, present one address, and compare the pulse and the flag in that single cycle. Each test also confirms that `dec_valid` is low one cycle later.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int ADDR_W = 48;
    localparam int WORD_W = 32;
    localparam int OFS_W  = 4;
    localparam int HASH_W = 6;
    localparam int NUM_STA = 2;
    localparam int CTRL_W = 4;

    localparam int N_SLICE = ADDR_W / HASH_W;
    localparam int TBL_N   = 1 << HASH_W;
    localparam int HI_W    = ADDR_W - WORD_W;

    // control bit positions
    localparam int CB_HASH_ALL = 2;
    localparam int CB_BCAST    = 3;

    // word offsets
    localparam logic [OFS_W-1:0] OFS_GRP_LO = 4'd4;
    localparam logic [OFS_W-1:0] OFS_GRP_HI = 4'd5;
    localparam logic [OFS_W-1:0] OFS_CTRL   = 4'd7;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } dec_state_e;
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
    import rxf_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_wr,
    input  logic [OFS_W-1:0]                  cfg_ofs,
    input  logic [WORD_W-1:0]                 cfg_data,
    output logic [NUM_STA-1:0][ADDR_W-1:0]    sta_addr,
    output logic [TBL_N-1:0]                  grp_tbl,
    output logic [CTRL_W-1:0]                 rx_ctrl
);
    for (genvar k = 0; k < NUM_STA; k++) begin : g_sta
        logic [ADDR_W-1:0] sa_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sa_q <= '0;
            end else if (cfg_wr) begin
                if (cfg_ofs == OFS_W'(2 * k))
                    sa_q[WORD_W-1:0] <= cfg_data;
                if (cfg_ofs == OFS_W'(2 * k + 1))
                    sa_q[ADDR_W-1:WORD_W] <= cfg_data[HI_W-1:0];
            end
        end
        assign sta_addr[k] = sa_q;
    end

    logic [WORD_W-1:0] grp_lo_q, grp_hi_q;
    logic [CTRL_W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_lo_q <= '0;
            grp_hi_q <= '0;
            ctrl_q   <= '0;
        end else if (cfg_wr) begin
            if (cfg_ofs == OFS_GRP_LO) grp_lo_q <= cfg_data;
            if (cfg_ofs == OFS_GRP_HI) grp_hi_q <= cfg_data;
            if (cfg_ofs == OFS_CTRL)   ctrl_q   <= cfg_data[CTRL_W-1:0];
        end
    end

    assign grp_tbl = {grp_hi_q, grp_lo_q};
    assign rx_ctrl = ctrl_q;
endmodule

// File: rtl/rxf_hash.sv
module rxf_hash
    import rxf_pkg::*;
(
    input  logic [ADDR_W-1:0] dst_addr,
    output logic [HASH_W-1:0] hash_idx
);
    always_comb begin
        hash_idx = '0;
        for (int s = 0; s < N_SLICE; s++)
            hash_idx = hash_idx ^ dst_addr[s*HASH_W +: HASH_W];
    end
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           addr_valid,
    input  logic [ADDR_W-1:0]              dst_addr,
    input  logic [NUM_STA-1:0][ADDR_W-1:0] sta_addr,
    input  logic [TBL_N-1:0]               grp_tbl,
    input  logic [CTRL_W-1:0]              rx_ctrl,
    input  logic [HASH_W-1:0]              hash_idx,
    output logic                           dec_valid,
    output logic                           dec_accept
);
    logic [NUM_STA-1:0] sta_hit;
    logic bc_hit, grp_hit, match;

    for (genvar k = 0; k < NUM_STA; k++) begin : g_cmp
        assign sta_hit[k] = rx_ctrl[k] && (dst_addr == sta_addr[k]);
    end

    assign bc_hit  = rx_ctrl[CB_BCAST] && (&dst_addr);
    assign grp_hit = (rx_ctrl[CB_HASH_ALL] || dst_addr[0]) && grp_tbl[hash_idx];
    assign match   = (|sta_hit) || bc_hit || grp_hit;

    dec_state_e state_q, state_d;
    logic       accept_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = addr_valid ? ST_REPORT : ST_IDLE;    // GO_REPORT
            ST_REPORT: state_d = addr_valid ? ST_REPORT : ST_IDLE;    // STAY_REPORT / BACK_IDLE
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            accept_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            accept_q <= addr_valid && match;
        end
    end

    always_comb begin
        dec_valid  = (state_q == ST_REPORT);
        dec_accept = dec_valid && accept_q;
    end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [OFS_W-1:0]  cfg_ofs,
    input  logic [WORD_W-1:0] cfg_data,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] dst_addr,
    output logic              dec_valid,
    output logic              dec_accept
);
    logic [NUM_STA-1:0][ADDR_W-1:0] sta_addr;
    logic [TBL_N-1:0]               grp_tbl;
    logic [CTRL_W-1:0]              rx_ctrl;
    logic [HASH_W-1:0]              hash_idx;

    rxf_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_ofs  (cfg_ofs),
        .cfg_data (cfg_data),
        .sta_addr (sta_addr),
        .grp_tbl  (grp_tbl),
        .rx_ctrl  (rx_ctrl)
    );

    rxf_hash u_hash (
        .dst_addr (dst_addr),
        .hash_idx (hash_idx)
    );

    rxf_decide u_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_valid (addr_valid),
        .dst_addr   (dst_addr),
        .sta_addr   (sta_addr),
        .grp_tbl    (grp_tbl),
        .rx_ctrl    (rx_ctrl),
        .hash_idx   (hash_idx),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept)
    );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
    import rxf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              addr_valid,
    input logic [ADDR_W-1:0] dst_addr,
    input logic              dec_valid,
    input logic              dec_accept,
    input logic [CTRL_W-1:0] rx_ctrl,
    input logic [TBL_N-1:0]  grp_tbl
);
    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> dec_valid);                                            // R2
    AST_NO_STRAY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> !dec_valid);                                          // R2
    AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !dec_accept);                                          // R2
    AST_BCAST_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && rx_ctrl[CB_BCAST] && (&dst_addr)) |=> dec_accept);     // R5
    AST_UNCONFIGURED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && rx_ctrl == '0 && grp_tbl == '0) |=> !dec_accept);      // R1
    AST_INDIVIDUAL_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && rx_ctrl[2:0] == 3'b000 && !dst_addr[0]) |=> !dec_accept); // R7
endmodule

bind rx_addr_filter rxf_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_valid (addr_valid),
    .dst_addr   (dst_addr),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .rx_ctrl    (rx_ctrl),
    .grp_tbl    (grp_tbl)
);

// File: tb/rx_addr_filter_tb.sv
`timescale 1ns/1ps
module rx_addr_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_ofs = '0;
    logic [31:0] cfg_data = '0;
    logic        addr_valid = 1'b0;
    logic [47:0] dst_addr = '0;
    logic        dec_valid, dec_accept;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rx_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ofs(cfg_ofs),
        .cfg_data(cfg_data), .addr_valid(addr_valid), .dst_addr(dst_addr),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_hash(input logic [47:0] a);
        logic [5:0] h = '0;
        for (int s = 0; s < 8; s++) h ^= a[s*6 +: 6];
        return h;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; addr_valid = 1'b0; cfg_wr = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset dec_valid", dec_valid, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] ofs, input logic [31:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_ofs = ofs; cfg_data = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic present(input logic [47:0] a, input logic exp, input string tag);
        @(negedge clk); addr_valid = 1'b1; dst_addr = a;
        @(negedge clk); addr_valid = 1'b0;
        check({tag, " R2 pulse"}, dec_valid, 1'b1);
        check(tag, dec_accept, exp);
        @(negedge clk);
        check({tag, " R2 pulse end"}, dec_valid, 1'b0);
    endtask

    task automatic set_grp_bit(input logic [5:0] idx);
        if (idx < 6'd32) wr(4'd4, 32'd1 << idx);
        else             wr(4'd5, 32'd1 << (idx - 6'd32));
    endtask

    task automatic t_reset_state();
        do_reset();
        present(48'hFFFF_FFFF_FFFF, 1'b0, "R1 bcast unconfigured");
        present(48'h0000_0000_0001, 1'b0, "R1 group unconfigured");
        present(48'h0000_0000_0000, 1'b0, "R1 zero addr");
    endtask

    task automatic t_back_to_back();
        do_reset();
        wr(4'd7, 32'h8);
        @(negedge clk); addr_valid = 1'b1; dst_addr = 48'hFFFF_FFFF_FFFF;
        @(negedge clk); dst_addr = 48'h1234_5678_9ABC;
        check("R2 b2b first valid", dec_valid, 1'b1);
        check("R2 b2b first accept", dec_accept, 1'b1);
        @(negedge clk); addr_valid = 1'b0;
        check("R2 b2b second valid", dec_valid, 1'b1);
        check("R2 b2b second accept", dec_accept, 1'b0);
        @(negedge clk);
        check("R2 b2b idle", dec_valid, 1'b0);
        check("R2 b2b idle accept", dec_accept, 1'b0);
    endtask

    task automatic t_station0();
        do_reset();
        wr(4'd0, 32'h4433_2211);
        wr(4'd1, 32'h0000_6655);
        wr(4'd7, 32'h1);
        present(48'h6655_4433_2211, 1'b1, "R3 station0 hit");
        present(48'h6655_4433_2210, 1'b0, "R3 station0 miss low byte");
        present(48'h6755_4433_2211, 1'b0, "R3 station0 miss high byte");
    endtask

    task automatic t_station1();
        do_reset();
        wr(4'd2, 32'hDDCC_BBAA);
        wr(4'd3, 32'h0000_FFEE);
        wr(4'd7, 32'h2);
        present(48'hFFEE_DDCC_BBAA, 1'b1, "R4 station1 hit");
        present(48'hFFEE_DDCC_BBAB, 1'b0, "R4 station1 miss");
    endtask

    task automatic t_bcast();
        do_reset();
        wr(4'd7, 32'h8);
        present(48'hFFFF_FFFF_FFFF, 1'b1, "R5 broadcast accepted");
        present(48'hFFFF_FFFF_FFFE, 1'b0, "R5 near-broadcast dropped");
    endtask

    task automatic t_hash();
        logic [47:0] a;
        logic [5:0]  h;
        do_reset();
        set_grp_bit(6'd1);
        present(48'h0000_0000_0001, 1'b1, "R6 hash idx1 low word");
        do_reset();
        set_grp_bit(6'd33);
        present(48'h0000_0000_0021, 1'b1, "R6 hash idx33 high word");
        present(48'h0000_0000_0001, 1'b0, "R6 hash idx1 not set");
        a = 48'h0123_4567_89AB;
        h = ref_hash(a);
        do_reset();
        set_grp_bit(h);
        present(a, 1'b1, "R6 hash folded addr hit");
        do_reset();
        set_grp_bit(h ^ 6'd1);
        present(a, 1'b0, "R6 hash folded addr neighbour bit");
    endtask

    task automatic t_individual();
        do_reset();
        set_grp_bit(6'd2);
        present(48'h0000_0000_0002, 1'b0, "R7 individual bypasses hash");
        wr(4'd7, 32'h4);
        present(48'h0000_0000_0002, 1'b1, "R7 hash-all mode individual hit");
    endtask

    task automatic t_disabled();
        do_reset();
        wr(4'd0, 32'h4433_2211);
        wr(4'd1, 32'h0000_6655);
        wr(4'd2, 32'hDDCC_BBAA);
        wr(4'd3, 32'h0000_FFEE);
        wr(4'd7, 32'h2);
        present(48'h6655_4433_2211, 1'b0, "R8 station0 disabled");
        wr(4'd7, 32'h1);
        present(48'hFFEE_DDCC_BBAA, 1'b0, "R8 station1 disabled");
    endtask

    task automatic t_ignored_writes();
        do_reset();
        wr(4'd6, 32'hFFFF_FFFF);
        wr(4'd8, 32'hFFFF_FFFF);
        wr(4'd15, 32'hFFFF_FFFF);
        present(48'hFFFF_FFFF_FFFF, 1'b0, "R9 stray offsets no effect bcast");
        present(48'h0000_0000_0001, 1'b0, "R9 stray offsets no effect group");
        wr(4'd0, 32'h0000_0000);
        wr(4'd1, 32'hABCD_1234);
        wr(4'd7, 32'hFFFF_FFF1);
        present(48'h1234_0000_0000, 1'b1, "R9 upper hi bits ignored");
        present(48'hFFFF_FFFF_FFFF, 1'b0, "R9 ctrl upper bits ignored");
    endtask

    task automatic t_combined();
        do_reset();
        wr(4'd0, 32'h0000_0010);
        wr(4'd7, 32'h9);
        set_grp_bit(6'd1);
        present(48'h0000_0000_0010, 1'b1, "R10 station source");
        present(48'hFFFF_FFFF_FFFF, 1'b1, "R10 broadcast source");
        present(48'h0000_0000_0001, 1'b1, "R10 hash source");
        present(48'h0000_0000_0020, 1'b0, "R10 no source");
    endtask

    initial begin
        t_reset_state();
        t_back_to_back();
        t_station0();
        t_station1();
        t_bcast();
        t_hash();
        t_individual();
        t_disabled();
        t_ignored_writes();
        t_combined();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule